// File: doc/BRIEF.md
# Reset Source Controller with Cause Flags

This block merges the internally generated reset requests of a small microcontroller into one system reset pulse. It also records which request caused the reset. There are two internal sources. The first is an underflow pulse from a watchdog counter, which is honoured only when software has enabled it. The second is a software trigger bit in a control register. A power-on reset input initialises the whole block.

Software reaches the block through a small register port. The write side uses an enable, an address and data. The read side uses an address and returns registered read data. Through this port software can:
- enable the watchdog reset source,
- set the two-bit processor-mode field,
- fire the software reset,
- select the CPU clock source,
- read and clear the cause flags.

An internal reset does not clear everything. The processor-mode field and the cause flags keep their values. The clock select is forced to the setting for the low-speed on-chip oscillator divided by 8. The block drives no clear signal towards memory, so RAM contents are left alone.

Register map, with the address on `wr_addr_i`/`rd_addr_i`:
- 0 is the control register: bit 0 is the watchdog reset enable, bit 1 is the software reset trigger, and bits 3:2 are the processor mode.
- 1 is the cause register: bit 0 means the watchdog caused a reset, and bit 1 means software did.
- 2 is the clock select register, bits 2:0. The code 4 means low-speed on-chip oscillator divided by 8.
- 3 reads as 0.

Unused bits read as 0.

Top module: `rstsrc_ctrl`

## Requirements
- R1: While `por_i` is high at a clock edge, everything is reset. After that edge `sys_rst_o` is 0, both cause flags are 0, the processor mode is 0, the watchdog enable and software trigger are 0, and `clk_sel_o` is 4.
- R2: With the enable bit (control bit 0) at 1, a watchdog underflow sampled at an edge drives `sys_rst_o` high from that edge.
- R3: With the enable bit at 0, a watchdog underflow causes no reset and leaves the cause flags unchanged.
- R4: A watchdog-caused reset sets cause bit 0 to 1.
- R5: Writing 1 to control bit 1 starts a reset at that write's edge and sets cause bit 1. The trigger bit then clears itself and reads 0 once the pulse ends.
- R6: The processor mode (control bits 3:2 and `pmode_o`) keeps its value through watchdog and software resets.
- R7: An internal reset forces `clk_sel_o` to 4 and clears the watchdog enable bit.
- R8: A watchdog underflow and a software trigger in the same cycle set both cause bits.
- R9: A cause bit is cleared only by writing 0 to it at address 1, or by power-on reset. Writing 1 to it has no effect.
- R10: In the cycle a reset starts and while `sys_rst_o` is high, register writes and watchdog underflows are ignored.
- R11: `sys_rst_o` stays high for exactly 4 cycles per reset and does not retrigger or stretch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| wdt_uflow_i | input | 1 | Watchdog underflow pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Registered read data, one cycle after the address |
| sys_rst_o | output | 1 | System reset pulse |
| clk_sel_o | output | 3 | CPU clock source select |
| pmode_o | output | 2 | Retained processor mode |

## Verification
A wrong pulse counter shows up directly on `sys_rst_o`: the pulse is too short, too long, or extended by a second trigger, and this is visible within the 4-cycle window. Errors in the retained state show up at the ports right after the pulse ends:
- a corrupted mode field appears on `pmode_o` at once;
- a lost or spurious cause flag appears on the first cause read;
- a failure to force the clock appears on `clk_sel_o` in the first reset cycle.

Gating faults are exercised by underflows with the source disabled, by writes during the pulse, and by simultaneous triggers.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int CSEL_W  = 3;
  localparam int PMODE_W = 2;

  localparam logic [CSEL_W-1:0] CSEL_LOCO_DIV8 = 3'd4;

  // control register bit positions
  localparam int CTL_WDT_EN = 0;
  localparam int CTL_SW_GO  = 1;
  localparam int CTL_PM_LO  = 2;

  // cause register bit positions
  localparam int CAU_WDT = 0;
  localparam int CAU_SW  = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_CAUSE  = 2'd1,
    A_CLKSEL = 2'd2,
    A_RSVD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rsc_pulse.sv
module rsc_pulse #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic por,
  input  logic wdt_uflow,
  input  logic wdt_en,
  input  logic sw_req,
  output logic hit_wdt,
  output logic hit_sw,
  output logic fire,
  output logic rst_q
);
  localparam int CNT_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] left_q;

  // Requests are dropped while a pulse is already running.
  assign hit_wdt = wdt_uflow & wdt_en & ~rst_q;
  assign hit_sw  = sw_req & ~rst_q;
  assign fire    = hit_wdt | hit_sw;

  always_ff @(posedge clk) begin
    if (por) begin
      rst_q  <= 1'b0;
      left_q <= '0;
    end else if (fire) begin
      rst_q  <= 1'b1;
      left_q <= CNT_W'(RST_LEN - 1);
    end else if (rst_q) begin
      if (left_q == '0) rst_q <= 1'b0;
      else left_q <= left_q - 1'b1;
    end
  end

  // Independent count of consecutive high cycles, used by the checks below.
  logic [CNT_W-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (por) hi_run <= '0;
    else if (rst_q) hi_run <= hi_run + 1'b1;
    else hi_run <= '0;
  end

  p_len_max_r11: assert property (@(posedge clk) disable iff (por)
    rst_q |-> hi_run < CNT_W'(RST_LEN));
  p_len_exact_r11: assert property (@(posedge clk) disable iff (por)
    $fell(rst_q) |-> hi_run == CNT_W'(RST_LEN));
endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
(
  input  logic               clk,
  input  logic               por,
  input  logic               busy,
  input  logic               fire,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [3:0]         wr_data,
  output logic               sw_req,
  output logic               wdt_en_q,
  output logic               sw_bit_q,
  output logic [PMODE_W-1:0] pmode_q,
  output logic [CSEL_W-1:0]  clk_sel_q
);
  logic wr_ok;

  assign sw_req = wr_en && (wr_addr == A_CTRL) && wr_data[CTL_SW_GO];
  assign wr_ok  = wr_en && !busy && !fire;

  always_ff @(posedge clk) begin
    if (por) begin
      wdt_en_q  <= 1'b0;
      sw_bit_q  <= 1'b0;
      pmode_q   <= '0;
      clk_sel_q <= CSEL_LOCO_DIV8;
    end else if (fire) begin
      // Internal reset: mode field is left untouched.
      wdt_en_q  <= 1'b0;
      sw_bit_q  <= sw_req;
      clk_sel_q <= CSEL_LOCO_DIV8;
    end else if (busy) begin
      sw_bit_q  <= 1'b0;
    end else if (wr_ok) begin
      if (wr_addr == A_CTRL) begin
        wdt_en_q <= wr_data[CTL_WDT_EN];
        pmode_q  <= wr_data[CTL_PM_LO +: PMODE_W];
      end
      if (wr_addr == A_CLKSEL) clk_sel_q <= wr_data[CSEL_W-1:0];
    end
  end

  p_pmode_hold_r6: assert property (@(posedge clk) disable iff (por)
    busy |-> $stable(pmode_q));
  p_clk_forced_r7: assert property (@(posedge clk) disable iff (por)
    $rose(busy) |-> (clk_sel_q == CSEL_LOCO_DIV8 && !wdt_en_q));
  p_sw_selfclr_r5: assert property (@(posedge clk) disable iff (por)
    (busy && $past(busy)) |-> !sw_bit_q);
endmodule

// File: rtl/rsc_cause.sv
module rsc_cause
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  logic       busy,
  input  logic       set_wdt,
  input  logic       set_sw,
  input  logic       clr_we,
  input  logic [1:0] clr_data,
  output logic       flag_wdt_q,
  output logic       flag_sw_q
);
  logic clr_ok;
  assign clr_ok = clr_we && !busy && !set_wdt && !set_sw;

  always_ff @(posedge clk) begin
    if (por) begin
      flag_wdt_q <= 1'b0;
      flag_sw_q  <= 1'b0;
    end else begin
      if (set_wdt) flag_wdt_q <= 1'b1;
      else if (clr_ok && !clr_data[CAU_WDT]) flag_wdt_q <= 1'b0;
      if (set_sw) flag_sw_q <= 1'b1;
      else if (clr_ok && !clr_data[CAU_SW]) flag_sw_q <= 1'b0;
    end
  end

  p_wdt_flag_src_r4: assert property (@(posedge clk) disable iff (por)
    $rose(flag_wdt_q) |-> $rose(busy));
  p_sw_flag_src_r5: assert property (@(posedge clk) disable iff (por)
    $rose(flag_sw_q) |-> $rose(busy));
  p_clear_only_r9: assert property (@(posedge clk) disable iff (por)
    $fell(flag_wdt_q) |-> $past(clr_we && !clr_data[CAU_WDT]));
endmodule

// File: rtl/rstsrc_ctrl.sv
module rstsrc_ctrl
  import rsc_pkg::*;
#(
  parameter int RST_LEN = 4
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic               wdt_uflow_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               sys_rst_o,
  output logic [CSEL_W-1:0]  clk_sel_o,
  output logic [PMODE_W-1:0] pmode_o
);
  logic sw_req, hit_wdt, hit_sw, fire, rst_q;
  logic wdt_en_q, sw_bit_q, flag_wdt_q, flag_sw_q;
  logic [PMODE_W-1:0] pmode_q;
  logic [CSEL_W-1:0]  clk_sel_q;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[DATA_W-1:4];

  rsc_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk(clk), .por(por_i), .wdt_uflow(wdt_uflow_i), .wdt_en(wdt_en_q),
    .sw_req(sw_req), .hit_wdt(hit_wdt), .hit_sw(hit_sw), .fire(fire),
    .rst_q(rst_q)
  );

  rsc_ctrl u_ctrl (
    .clk(clk), .por(por_i), .busy(rst_q), .fire(fire), .wr_en(wr_en_i),
    .wr_addr(wr_addr_i), .wr_data(wr_data_i[3:0]), .sw_req(sw_req),
    .wdt_en_q(wdt_en_q), .sw_bit_q(sw_bit_q), .pmode_q(pmode_q),
    .clk_sel_q(clk_sel_q)
  );

  rsc_cause u_cause (
    .clk(clk), .por(por_i), .busy(rst_q), .set_wdt(hit_wdt), .set_sw(hit_sw),
    .clr_we(wr_en_i && wr_addr_i == A_CAUSE), .clr_data(wr_data_i[1:0]),
    .flag_wdt_q(flag_wdt_q), .flag_sw_q(flag_sw_q)
  );

  always_ff @(posedge clk) begin
    if (por_i) rd_data_o <= '0;
    else begin
      rd_data_o <= '0;
      case (rd_addr_i)
        A_CTRL: begin
          rd_data_o[CTL_WDT_EN]             <= wdt_en_q;
          rd_data_o[CTL_SW_GO]              <= sw_bit_q;
          rd_data_o[CTL_PM_LO +: PMODE_W]   <= pmode_q;
        end
        A_CAUSE: begin
          rd_data_o[CAU_WDT] <= flag_wdt_q;
          rd_data_o[CAU_SW]  <= flag_sw_q;
        end
        A_CLKSEL: rd_data_o[CSEL_W-1:0] <= clk_sel_q;
        default:  rd_data_o <= '0;
      endcase
    end
  end

  assign sys_rst_o = rst_q;
  assign clk_sel_o = clk_sel_q;
  assign pmode_o   = pmode_q;

  p_wdt_gate_r3: assert property (@(posedge clk) disable iff (por_i)
    (wdt_uflow_i && !wdt_en_q && !sys_rst_o && !sw_req) |=> !sys_rst_o);
  p_both_flags_r8: assert property (@(posedge clk) disable iff (por_i)
    (hit_wdt && hit_sw) |=> (flag_wdt_q && flag_sw_q));
endmodule

// File: tb/rstsrc_ctrl_tb.sv
`timescale 1ns/1ps
module rstsrc_ctrl_tb;
  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       wdt_uflow_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       sys_rst_o;
  logic [2:0] clk_sel_o;
  logic [1:0] pmode_o;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string tag; logic [7:0] exp; } exp_t;
  exp_t sb_q[$];
  logic chk_req = 1'b0, chk_due = 1'b0;

  always #4 clk = ~clk;

  rstsrc_ctrl u_dut (
    .clk(clk), .por_i(por_i), .wdt_uflow_i(wdt_uflow_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .sys_rst_o(sys_rst_o), .clk_sel_o(clk_sel_o),
    .pmode_o(pmode_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) chk_due <= chk_req;
  always @(negedge clk) begin
    if (chk_due && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.tag, int'(rd_data_o), int'(e.exp));
    end
  end

  task automatic rd_expect(logic [1:0] a, logic [7:0] exp, string tag);
    exp_t e;
    @(negedge clk);
    rd_addr_i = a;
    e.tag = tag; e.exp = exp;
    sb_q.push_back(e);
    chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic uflow();
    @(negedge clk);
    wdt_uflow_i = 1'b1;
    @(negedge clk);
    wdt_uflow_i = 1'b0;
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (sys_rst_o && n < 20) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic por_seq();
    @(negedge clk);
    por_i = 1'b1;
    repeat (3) @(negedge clk);
    por_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int n;
    por_seq();
    // R1 reset state
    chk("R1 sys_rst", sys_rst_o, 0);
    chk("R1 clk_sel", clk_sel_o, 4);
    chk("R1 pmode", pmode_o, 0);
    rd_expect(2'd1, 8'h00, "R1 cause");
    rd_expect(2'd0, 8'h00, "R1 ctrl");

    // R3 underflow with source disabled
    wr(2'd0, 8'h08);
    chk("R6 pmode set", pmode_o, 2);
    uflow();
    repeat (3) begin chk("R3 no reset", sys_rst_o, 0); @(negedge clk); end
    rd_expect(2'd1, 8'h00, "R3 cause unchanged");

    // R2/R4/R6/R7/R11 watchdog reset
    wr(2'd0, 8'h09);
    wr(2'd2, 8'h01);
    chk("R7 clk_sel written", clk_sel_o, 1);
    uflow();
    chk("R2 reset asserted", sys_rst_o, 1);
    chk("R7 clk forced", clk_sel_o, 4);
    pulse_len(n);
    chk("R11 wdt pulse length", n, 4);
    chk("R6 pmode kept wdt", pmode_o, 2);
    rd_expect(2'd0, 8'h08, "R7 enable cleared");
    rd_expect(2'd1, 8'h01, "R4 wdt flag");

    // R9 clearing
    wr(2'd1, 8'h03);
    rd_expect(2'd1, 8'h01, "R9 write one no effect");
    wr(2'd1, 8'h00);
    rd_expect(2'd1, 8'h00, "R9 write zero clears");

    // R5 software reset
    wr(2'd0, 8'h0A);
    chk("R5 reset asserted", sys_rst_o, 1);
    pulse_len(n);
    chk("R11 sw pulse length", n, 4);
    chk("R6 pmode kept sw", pmode_o, 2);
    rd_expect(2'd0, 8'h08, "R5 trigger self-cleared");
    rd_expect(2'd1, 8'h02, "R5 sw flag");

    // R10 activity during pulse is ignored
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h09);
    wr(2'd0, 8'h0B);
    chk("R10 pulse started", sys_rst_o, 1);
    wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'h07; wdt_uflow_i = 1'b1;
    repeat (3) begin @(negedge clk); chk("R10 still in pulse", sys_rst_o, 1); end
    wr_en_i = 1'b0; wdt_uflow_i = 1'b0;
    @(negedge clk);
    chk("R11 no stretch", sys_rst_o, 0);
    repeat (2) begin @(negedge clk); chk("R11 no retrigger", sys_rst_o, 0); end
    chk("R10 pmode untouched", pmode_o, 2);
    rd_expect(2'd0, 8'h08, "R10 ctrl unchanged");
    rd_expect(2'd1, 8'h02, "R10 cause unchanged");

    // R8 simultaneous sources
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h09);
    @(negedge clk);
    wdt_uflow_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'h0B;
    @(negedge clk);
    wdt_uflow_i = 1'b0; wr_en_i = 1'b0;
    pulse_len(n);
    chk("R8 pulse length", n, 4);
    rd_expect(2'd1, 8'h03, "R8 both flags");

    // R1 power-on clears retained state
    por_seq();
    chk("R1 pmode after por", pmode_o, 0);
    rd_expect(2'd1, 8'h00, "R1 cause after por");
    @(negedge clk);
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule